// File: doc/BRIEF.md
# Gaussian Sample Averaging Accumulator

This block follows a quantized Box-Muller noise source and smooths its distribution by the central limit theorem. Each output sample is built from four consecutive accepted input samples. An input sample is a 9-bit two's-complement value with 6 fractional bits, and it is accepted only in a cycle where its strobe is high. The block emits one output sample per group of four, with a single-cycle strobe.

The source negates samples by one's complement, so every sample has a mean of -2^-7. The group sum therefore has a mean of -2^-5, which is two input LSBs, and the block adds two LSBs to cancel it. The sum of four unit-variance samples has a standard deviation of two, so the compensated sum is halved with an arithmetic shift. The result is a 12-bit two's-complement sample with 6 fractional bits. Scaling the noise for a target SNR and adding it to a signal are left to the stage that follows.

Top module: `clt_gauss_accum`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid is 0 and out_sample is 0.
- R2: out_valid goes high in the cycle that follows the clock edge that accepts the 4th, 8th, 12th, ... sample since reset. It is low in all other cycles.
- R3: A cycle with in_valid low has no effect. Its in_sample value does not enter any sum, and the group position does not advance.
- R4: Each group gives out_sample = floor((s0+s1+s2+s3+2)/2). Every value counts in LSBs of 2^-6, and out_sample is 12-bit two's complement.
- R5: Each group starts from zero, so earlier groups do not affect its result, and back-to-back groups with no idle cycles are handled.
- R6: Between pulses of out_valid, out_sample holds its last value.
- R7: out_valid is never high in two consecutive cycles.
- R8: Full-scale groups map without wrap. Four samples of -256 give -511, and four samples of +255 give +511.
- R9: in_sample is read as 9-bit two's complement, bit 8 being the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present this cycle |
| in_sample | input | 9 | Signed input sample, 6 fractional bits |
| out_valid | output | 1 | One-cycle strobe for a new output sample |
| out_sample | output | 12 | Signed averaged sample, 6 fractional bits |

## Verification
A group counter that slips shows up on the first group after the slip. The strobe then appears early or late against the bench's count of accepted samples, and that is caught in the cycle it should have fired. An accumulator that fails to clear, or that takes in idle-cycle data, gives a wrong value on the very next strobe. The mixed-sign and full-scale groups expose a missing bias, a logical shift used in place of an arithmetic one, or a width that wraps.

// File: rtl/clt_gauss_accum.sv
module clt_gauss_accum #(
  parameter int IN_W   = 9,
  parameter int OUT_W  = 12,
  parameter int GROUP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_sample
);

  localparam int CNT_W = $clog2(GROUP);
  localparam int ACC_W = IN_W + CNT_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP - 1);
  localparam logic signed [ACC_W-1:0] BIAS = ACC_W'(GROUP / 2);

  logic [CNT_W-1:0]        pos;
  logic signed [ACC_W-1:0] acc;

  wire signed [ACC_W-1:0] ext      = ACC_W'($signed(in_sample));
  wire signed [ACC_W-1:0] base     = (pos == '0) ? '0 : acc;
  wire signed [ACC_W-1:0] sum_next = base + ext;
  wire signed [ACC_W-1:0] unbiased = sum_next + BIAS;
  wire signed [ACC_W-1:0] scaled   = unbiased >>> 1;
  wire                    done     = in_valid && (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= '0;
      acc        <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= done;
      if (in_valid) begin
        pos <= pos + 1'b1;
        acc <= sum_next;
      end
      if (done)
        out_sample <= OUT_W'(scaled);
    end
  end

endmodule

// File: rtl/clt_gauss_accum_chk.sv
module clt_gauss_accum_chk #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 12,
  parameter int GROUP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_sample,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sample
);

  int seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if (in_valid) seen <= (seen == GROUP - 1) ? 0 : seen + 1;
  end

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sample));

  assert_fire_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seen == GROUP - 1) |=> out_valid);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && seen == GROUP - 1) |=> !out_valid);

  assert_range_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_sample) >= -512 && $signed(out_sample) <= 511));

endmodule

bind clt_gauss_accum clt_gauss_accum_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .GROUP(GROUP)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/clt_gauss_accum_test.sv
module clt_gauss_accum_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [8:0]  in_sample = '0;
  logic        out_valid;
  logic [11:0] out_sample;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  logic prev_v = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clt_gauss_accum uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_sample = 9'($urandom);
    end
  endtask

  task automatic send_group(input int s0, input int s1, input int s2, input int s3,
                            input int gap, input string tag);
    int s[4];
    int sum;
    s = '{s0, s1, s2, s3};
    sum = s0 + s1 + s2 + s3 + 2;
    exp_q.push_back(sum >>> 1);
    tag_q.push_back(tag);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_sample = 9'(s[i]);
      if (i < 3 && gap > 0) idle(gap);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_sample = 9'($urandom);
    @(negedge clk);
    check("R2 strobe after 4th sample", int'(out_valid), 1);
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid && prev_v) check("R7 one-cycle strobe", 1, 0);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected strobe", 1, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'($signed(out_sample)), e);
        end
      end
      prev_v = out_valid;
    end
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_sample in reset", int'(out_sample), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_sample after reset", int'(out_sample), 0);

    send_group(1, 2, 3, 4, 0, "R4 small positive");
    send_group(-5, -7, 3, 0, 0, "R9 R4 mixed sign floor");
    send_group(-1, -1, -1, -1, 0, "R9 all minus one LSB");
    send_group(10, -20, 30, -41, 2, "R3 idle cycles ignored");
    send_group(-256, -256, -256, -256, 0, "R8 negative full scale");
    send_group(255, 255, 255, 255, 0, "R8 positive full scale");

    exp_q.push_back((7 + 8 + 9 + 10 + 2) >>> 1);
    tag_q.push_back("R5 first back-to-back");
    exp_q.push_back((-100 + 50 - 3 + 0 + 2) >>> 1);
    tag_q.push_back("R5 second back-to-back");
    begin
      int seq[8];
      seq = '{7, 8, 9, 10, -100, 50, -3, 0};
      for (int i = 0; i < 8; i++) begin
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_sample = 9'(seq[i]);
      end
    end
    idle(3);

    held = int'($signed(out_sample));
    idle(10);
    @(negedge clk);
    check("R6 output held while idle", int'($signed(out_sample)), held);
    check("R3 no strobe while idle", int'(out_valid), 0);

    send_group(0, 0, 0, 0, 1, "R4 zero group bias");
    idle(3);
    @(negedge clk);
    check("R2 all groups delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule